// File: doc/BRIEF.md
# Mantissa-Exponent Wake-Up Timer

This block keeps time from the 32.768 kHz low-power clock of a radio controller and raises a wake event at a fixed period while the rest of the chip sleeps. Software sets the period with a 16-bit mantissa M, written as two bytes, and a 5-bit exponent R. The period is 4 × M × 2^R ticks, and any exponent above a clamp limit (20 by default) counts as the limit. A control byte starts and stops the timer and chooses whether each expiry raises the active-low interrupt. A status read clears the interrupt. The current mantissa count can be read at any time.

In low-duty-cycle mode, each wake also opens a receive window that lasts a programmed number of ticks. If the radio reports a valid preamble or sync word while the window is open, the window is held open for software to handle. If nothing is seen, the window closes and the radio goes back to sleep until the next period.

The register port is byte wide. Writes take effect at the clock edge. Read data follows the read address combinationally.

Top module: `wake_timer`

## Requirements
- R1: After reset, `wake`=0, `irq_n`=1, `rx_on`=0, and every register reads 0. The register map is: address 0 control (bit0 run, bit1 interrupt enable, bit2 low-duty mode), 1 exponent [4:0], 2 mantissa high byte, 3 mantissa low byte, 4 window length, 5 status (bit0 wake flag), 6 count high byte, 7 count low byte.
- R2: When run is set by a write at clock edge n, `wake` pulses high for one cycle after edge n+P, n+2P and so on, where P = 4·M·2^R.
- R3: An exponent above EXP_CLAMP (parameter, default 20) acts as EXP_CLAMP.
- R4: The count at addresses 6/7 starts at 0, steps up once every 4·2^R ticks and returns to 0 at each wake.
- R5: When interrupt enable is set, each wake sets status bit0 and `irq_n` goes low in the same cycle as `wake`. `irq_n` is low whenever the flag and the enable are both set.
- R6: A read of address 5 returns the flag and clears it at the next edge. If an expiry happens on that same edge, the expiry wins and the flag stays set.
- R7: When interrupt enable is clear, `wake` still pulses, but the flag is not set and `irq_n` stays high.
- R8: Writes to addresses 1–4 are ignored while run is set. Writes to the control register are always accepted. Clearing run stops the count, returns it to 0 and stops wakes.
- R9: A mantissa of zero gives no wake pulses, and the count stays at 0.
- R10: In low-duty mode with window length W>0, `rx_on` goes high in the cycle of the wake and stays high for exactly W cycles.
- R11: If `sig_detect` is high in an open window, `rx_on` stays high until low-duty mode or run is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz low-power clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a status read clears the flag) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| sig_detect | input | 1 | Preamble or sync word seen by the radio |
| wake | output | 1 | One-cycle wake pulse |
| irq_n | output | 1 | Active-low interrupt |
| rx_on | output | 1 | Receive window open |

## Verification
The period is tried with three mantissa/exponent pairs, (3,0), (2,1) and (1,9) under a reduced clamp of 3. Between them these separate the prescale factor, the power-of-two shift and the clamp. A scoreboard predicts the exact cycle of every wake. This also shows that a mantissa written while the timer runs leaves the period unchanged, and that a zero mantissa yields no wakes at all. Runs with the interrupt enable on and off tell the wake path apart from the interrupt path. Two low-duty passes, one with no detection and one with a detection inside the window, tell the timed close apart from the held window.

// File: rtl/wut_pkg.sv
package wut_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_EXP    = 3'd1;
  localparam logic [2:0] A_MHI    = 3'd2;
  localparam logic [2:0] A_MLO    = 3'd3;
  localparam logic [2:0] A_WIN    = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;
  localparam logic [2:0] A_CHI    = 3'd6;
  localparam logic [2:0] A_CLO    = 3'd7;

  // exponent after clamping to the configured limit
  function automatic int unsigned eff_exp(input logic [4:0] r, input int unsigned lim);
    return (int'(r) > lim) ? lim : int'(r);
  endfunction

  // last prescale count: 4 * 2^R - 1
  function automatic logic [31:0] prescale_last(input logic [4:0] r, input int unsigned lim);
    return (32'd4 << eff_exp(r, lim)) - 32'd1;
  endfunction
endpackage

// File: rtl/wut_regs.sv
module wut_regs
  import wut_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EXP_W  = 5,
  parameter int WIN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [2:0]          rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                expire,
  input  logic [2*DATA_W-1:0] cnt,
  output logic                run,
  output logic                ien,
  output logic                ldc,
  output logic [EXP_W-1:0]    exp_r,
  output logic [2*DATA_W-1:0] mant,
  output logic [WIN_W-1:0]    win_len,
  output logic                flag
);
  logic status_read;
  assign status_read = rd_en && (rd_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; ien <= 1'b0; ldc <= 1'b0;
      exp_r <= '0; mant <= '0; win_len <= '0; flag <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_addr == A_CTRL) begin
          run <= wr_data[0];
          ien <= wr_data[1];
          ldc <= wr_data[2];
        end else if (!run) begin
          case (wr_addr)
            A_EXP:   exp_r <= wr_data[EXP_W-1:0];
            A_MHI:   mant[2*DATA_W-1:DATA_W] <= wr_data;
            A_MLO:   mant[DATA_W-1:0] <= wr_data;
            A_WIN:   win_len <= wr_data[WIN_W-1:0];
            default: ;
          endcase
        end
      end
      if (expire && ien) flag <= 1'b1;
      else if (status_read) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data = DATA_W'({ldc, ien, run});
      A_EXP:    rd_data = DATA_W'(exp_r);
      A_MHI:    rd_data = mant[2*DATA_W-1:DATA_W];
      A_MLO:    rd_data = mant[DATA_W-1:0];
      A_WIN:    rd_data = DATA_W'(win_len);
      A_STATUS: rd_data = DATA_W'(flag);
      A_CHI:    rd_data = cnt[2*DATA_W-1:DATA_W];
      A_CLO:    rd_data = cnt[DATA_W-1:0];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wut_counter.sv
module wut_counter
  import wut_pkg::*;
#(
  parameter int MANT_W    = 16,
  parameter int EXP_W     = 5,
  parameter int EXP_CLAMP = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  exp_r,
  output logic [MANT_W-1:0] cnt,
  output logic              expire,
  output logic              wake
);
  localparam int PW = EXP_CLAMP + 2;

  logic [PW-1:0]     pre;
  logic [PW-1:0]     pre_top;
  logic [MANT_W-1:0] mant_top;
  logic              active;
  logic              pre_wrap;

  assign pre_top  = PW'(prescale_last(exp_r, EXP_CLAMP));
  assign mant_top = mant - MANT_W'(1);
  assign active   = run && (mant != '0);
  assign pre_wrap = (pre == pre_top);
  assign expire   = active && pre_wrap && (cnt == mant_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; wake <= 1'b0;
    end else begin
      wake <= expire;
      if (!active) begin
        pre <= '0;
        cnt <= '0;
      end else if (pre_wrap) begin
        pre <= '0;
        cnt <= (cnt == mant_top) ? '0 : cnt + MANT_W'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/wut_window.sv
module wut_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             expire,
  input  logic [WIN_W-1:0] win_len,
  input  logic             sig_detect,
  output logic             rx_on
);
  typedef enum logic [1:0] {W_IDLE, W_OPEN, W_HELD} win_state_t;
  win_state_t      st;
  logic [WIN_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; left <= '0;
    end else if (!arm) begin
      st <= W_IDLE; left <= '0;
    end else begin
      case (st)
        W_IDLE: if (expire && win_len != '0) begin
          st <= W_OPEN; left <= win_len;
        end
        W_OPEN: begin
          if (sig_detect) st <= W_HELD;
          else if (left == WIN_W'(1)) st <= W_IDLE;
          else left <= left - WIN_W'(1);
        end
        W_HELD: st <= W_HELD;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign rx_on = (st != W_IDLE);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int EXP_CLAMP = 20,
  parameter int WIN_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sig_detect,
  output logic       wake,
  output logic       irq_n,
  output logic       rx_on
);
  localparam int DATA_W = 8;
  localparam int MANT_W = 2 * DATA_W;
  localparam int EXP_W  = 5;

  logic              expire_evt;
  logic              run_q, ien_q, ldc_q, flag_q;
  logic [EXP_W-1:0]  exp_q;
  logic [MANT_W-1:0] mant_q, cnt_q;
  logic [WIN_W-1:0]  win_q;
  logic              mant_zero;

  assign mant_zero = (mant_q == '0);

  wut_regs #(.DATA_W(DATA_W), .EXP_W(EXP_W), .WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .expire(expire_evt),
    .cnt(cnt_q), .run(run_q), .ien(ien_q), .ldc(ldc_q), .exp_r(exp_q),
    .mant(mant_q), .win_len(win_q), .flag(flag_q)
  );

  wut_counter #(.MANT_W(MANT_W), .EXP_W(EXP_W), .EXP_CLAMP(EXP_CLAMP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .mant(mant_q), .exp_r(exp_q),
    .cnt(cnt_q), .expire(expire_evt), .wake(wake)
  );

  wut_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(run_q && ldc_q), .expire(expire_evt),
    .win_len(win_q), .sig_detect(sig_detect), .rx_on(rx_on)
  );

  assign irq_n = !(flag_q && ien_q);
endmodule

// File: rtl/wut_checker.sv
module wut_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        rd_en,
  input logic [2:0]  rd_addr,
  input logic        wake,
  input logic        irq_n,
  input logic        rx_on,
  input logic        expire_evt,
  input logic        run_q,
  input logic        ien_q,
  input logic        flag_q,
  input logic        mant_zero,
  input logic [15:0] mant_q,
  input logic [15:0] cnt_q
);
  logic ctrl_write;
  assign ctrl_write = wr_en && (wr_addr == 3'd0);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mant_zero |-> (cnt_q < mant_q));
  assert_irq_after_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && ien_q && !ctrl_write) |=> !irq_n);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd5 && !expire_evt) |=> !flag_q);
  assert_no_flag_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !flag_q) |=> !flag_q);
  assert_stopped_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !wake);
  assert_zero_mant_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mant_zero |-> (cnt_q == 16'd0 && !expire_evt));
  assert_window_on_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> wake);
endmodule

bind wake_timer wut_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
  .rd_addr(rd_addr), .wake(wake), .irq_n(irq_n), .rx_on(rx_on),
  .expire_evt(expire_evt), .run_q(run_q), .ien_q(ien_q), .flag_q(flag_q),
  .mant_zero(mant_zero), .mant_q(mant_q), .cnt_q(cnt_q)
);

// File: tb/wake_timer_tb.sv
`timescale 1ns/1ps
module wake_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, sig_detect = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wake, irq_n, rx_on;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  int e_pop;
  bit done = 0;

  // reduced clamp so the clamp case fits in a short run
  localparam int TB_CLAMP = 3;

  wake_timer #(.EXP_CLAMP(TB_CLAMP), .WIN_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sig_detect(sig_detect),
    .wake(wake), .irq_n(irq_n), .rx_on(rx_on)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int period(input int m, input int r);
    int rr = (r > TB_CLAMP) ? TB_CLAMP : r;
    return 4 * m * (1 << rr);
  endfunction

  // scoreboard monitor: every wake must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && wake) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: actual wake at cycle %0d expected none", cyc);
      end else begin
        e_pop = exp_q.pop_front();
        if (e_pop != cyc) begin
          errors++;
          $display("FAIL R2: actual wake at cycle %0d expected %0d", cyc, e_pop);
        end
      end
    end
  end

  task automatic push_wakes(input int n, input int p, input int k);
    for (int i = 1; i <= k; i++) exp_q.push_back(n + i * p);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output int edge_no);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    edge_no = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setup(input int m, input int r, input int w);
    int n;
    wr(3'd1, 8'(r), n);
    wr(3'd2, 8'(m >> 8), n);
    wr(3'd3, 8'(m), n);
    wr(3'd4, 8'(w), n);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wake", wake, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 rx_on", rx_on, 0);
    rd(3'd3, v); chk("R1 mantissa low", v, 0);
    rd(3'd5, v); chk("R1 status", v, 0);
    rd(3'd7, v); chk("R1 count low", v, 0);

    // Phase A: M=3 R=0, interrupt on
    setup(3, 0, 0);
    wr(3'd0, 8'h03, n);
    push_wakes(n, period(3, 0), 3);
    wait_until(n + 5);
    rd(3'd7, v); chk("R4 count mid-period", v, 1);
    wait_until(n + 13);
    chk("R5 irq_n after wake", irq_n, 0);
    rd(3'd5, v); chk("R5 status flag", v, 1);
    chk("R6 irq_n after status read", irq_n, 1);
    wr(3'd3, 8'd50, v); // R8 ignored while running
    rd(3'd3, v); chk("R8 mantissa unchanged", v, 3);
    wait_until(n + 40);
    wr(3'd0, 8'h00, v);
    rd(3'd5, v); chk("R5 flag set by later wake", v, 1);
    wait_until(n + 60);
    chk("R2 all wakes seen A", exp_q.size(), 0);
    rd(3'd7, v); chk("R8 count cleared when stopped", v, 0);

    // Phase B: M=2 R=1, interrupt off
    setup(2, 1, 0);
    wr(3'd0, 8'h01, n);
    push_wakes(n, period(2, 1), 2);
    wait_until(n + 17);
    chk("R7 irq_n stays high", irq_n, 1);
    rd(3'd5, v); chk("R7 no flag", v, 0);
    wait_until(n + 40);
    wr(3'd0, 8'h00, v);
    wait_until(n + 52);
    chk("R2 all wakes seen B", exp_q.size(), 0);

    // Phase C: exponent 9 clamps to TB_CLAMP
    setup(1, 9, 0);
    wr(3'd0, 8'h01, n);
    push_wakes(n, period(1, 9), 2); // R3
    wait_until(n + 70);
    wr(3'd0, 8'h00, v);
    wait_until(n + 80);
    chk("R3 clamped period wakes", exp_q.size(), 0);

    // Phase D: zero mantissa
    setup(0, 0, 0);
    wr(3'd0, 8'h03, n);
    wait_until(n + 60);
    rd(3'd7, v); chk("R9 count low stays 0", v, 0);
    rd(3'd6, v); chk("R9 count high stays 0", v, 0);
    chk("R9 irq_n high", irq_n, 1);
    wr(3'd0, 8'h00, v);

    // Phase E: low-duty window, W=5, M=4 R=0
    setup(4, 0, 5);
    wr(3'd0, 8'h05, n);
    push_wakes(n, period(4, 0), 2);
    wait_until(n + 15);
    chk("R10 window closed before wake", rx_on, 0);
    wait_until(n + 16);
    chk("R10 window opens with wake", rx_on, 1);
    wait_until(n + 20);
    chk("R10 window open last cycle", rx_on, 1);
    wait_until(n + 21);
    chk("R10 window closed after W", rx_on, 0);
    wait_until(n + 33);
    sig_detect = 1'b1;
    @(negedge clk);
    sig_detect = 1'b0;
    wait_until(n + 40);
    chk("R11 window held after detect", rx_on, 1);
    wr(3'd0, 8'h00, v);
    wait_until(n + 42);
    chk("R11 window released by control", rx_on, 0);
    wait_until(n + 60);
    chk("R2 all wakes seen E", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule